// File: doc/BRIEF.md
# Wrapped-Order Line Refill Engine

This block services one cache-line refill at a time when a line holds several words and the memory path carries only one word per transfer. On a miss it asks memory for the word the CPU actually wanted before any other, hands that word to the CPU in the same cycle it comes back so the pipeline can restart, and then keeps fetching the other words of the line. The order continues upward from the missed word and wraps past the last word of the line back to word 0.

Every returned word is written into the cache data array as it arrives. A per-word arrival mask lets the CPU probe the line while the refill is still running. A probe to a word that is already present is answered from the refill buffer, and a probe to a missing word is told to stall. Once the last word has been written, a one-cycle done flag tells the cache to mark the line valid. Only one memory request is in flight at any time, and responses may come back after any number of idle cycles.

Top module: `cwf_refill`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the engine is idle: `miss_ready` is 1, and `mem_req_valid`, `array_we`, `cpu_early_valid`, `fill_done`, `probe_hit` and `probe_stall` are all 0.
- R2: When a miss is accepted (`miss_valid` high while `miss_ready` is high), the next cycle raises `mem_req_valid`. This first request carries `mem_req_line` equal to the accepted line and `mem_req_off` equal to the accepted word offset.
- R3: Each later request of the same refill uses the previous request's offset plus one, modulo WORDS. A refill therefore issues exactly WORDS requests and visits every offset once.
- R4: A request stays asserted with an unchanged offset until `mem_req_ready` is seen. After acceptance, `mem_req_valid` stays low until the matching `mem_rsp_valid` arrives, whatever the gap, so at most one request is outstanding.
- R5: In the cycle the response to the first request arrives, `cpu_early_valid` is 1, with `cpu_early_data` equal to the response data and `cpu_early_off` equal to the missed offset. This happens exactly once per refill.
- R6: Every response is written to the data array in the same cycle it arrives: `array_we` is 1, `array_line` is the refill line, `array_off` is the offset of the outstanding request, and `array_data` is the response data. `array_we` is 0 in every other cycle.
- R7: `fill_done` is a single-cycle pulse in the cycle after the WORDS-th array write, with `array_line` still showing the line. `miss_ready` is 0 from the cycle after acceptance through that pulse, and returns to 1 on the following cycle.
- R8: While a refill is active (from the cycle after acceptance through the done cycle), a probe with `probe_valid` high and `probe_line` equal to the refill line behaves as follows. If that word was written in an earlier cycle, the probe gets `probe_hit` with the stored word on `probe_data`. Otherwise it gets `probe_stall`. Probes to any other line, or probes made while idle, raise neither signal.
- R9: A `miss_valid` raised while a refill is active is ignored: requests keep the original line and continue the wrapped offset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Engine idle and able to take a miss |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset that missed |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W | Requested line address |
| mem_req_off | output | OFF_W | Requested word offset |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | WORD_W | Returned word |
| cpu_early_valid | output | 1 | Missed word forwarded to CPU |
| cpu_early_off | output | OFF_W | Offset of forwarded word |
| cpu_early_data | output | WORD_W | Forwarded word |
| array_we | output | 1 | Data array word write enable |
| array_line | output | LINE_W | Line being written |
| array_off | output | OFF_W | Word position being written |
| array_data | output | WORD_W | Word being written |
| fill_done | output | 1 | Whole line written, mark it valid |
| probe_valid | input | 1 | CPU access during refill |
| probe_line | input | LINE_W | Line of the CPU access |
| probe_off | input | OFF_W | Word of the CPU access |
| probe_hit | output | 1 | Access served from arrived words |
| probe_stall | output | 1 | Access must wait for its word |
| probe_data | output | WORD_W | Data for a served access |

## Verification
A corrupted offset register shows up at the next request, on `mem_req_off`, as a break in the wrapped sequence. It also reaches the array write in the cycle the response returns. A wrong word counter either moves `fill_done` off the cycle that follows the last write or repeats the early-data pulse, and this is visible within one refill. A bad arrival mask flips `probe_hit` against `probe_stall` on the very next probe to the affected word. The reference model in the bench compares all of these outputs on every cycle, so the first faulty cycle is reported.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } fill_state_e;

    typedef struct packed {
        logic hit;
        logic stall;
    } probe_res_t;

    // Next offset in wrapped order around a line of 'words' entries.
    function automatic int unsigned wrap_next(input int unsigned off,
                                              input int unsigned words);
        return (off + 1 >= words) ? 0 : off + 1;
    endfunction

endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
    import cwf_pkg::*;
#(
    parameter  int WORDS  = 4,
    parameter  int LINE_W = 26,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_off,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic              miss_ready,
    output logic              start,
    output logic              busy,
    output logic              mem_req_valid,
    output logic              word_take,
    output logic              first_word,
    output logic              fill_done,
    output logic [LINE_W-1:0] line_q,
    output logic [OFF_W-1:0]  cur_off
);
    localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);

    fill_state_e      state_q;
    logic [OFF_W-1:0] cnt_q;
    logic [OFF_W-1:0] cur_q;

    assign miss_ready    = (state_q == ST_IDLE);
    assign start         = miss_ready && miss_valid;
    assign busy          = !miss_ready;
    assign mem_req_valid = (state_q == ST_REQ);
    assign word_take     = (state_q == ST_WAIT) && mem_rsp_valid;
    assign first_word    = (cnt_q == '0);
    assign fill_done     = (state_q == ST_DONE);
    assign cur_off       = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            cur_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (miss_valid) begin
                    line_q  <= miss_line;
                    cur_q   <= miss_off;
                    cnt_q   <= '0;
                    state_q <= ST_REQ;
                end
                ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    cur_q   <= OFF_W'(wrap_next(32'(cur_q), WORDS));
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= (cnt_q == LAST_CNT) ? ST_DONE : ST_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(cur_off)));

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (!fill_done && miss_ready));

endmodule

// File: rtl/cwf_linebuf.sv
module cwf_linebuf
    import cwf_pkg::*;
#(
    parameter  int WORDS  = 4,
    parameter  int WORD_W = 32,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              probe_en,
    input  logic [OFF_W-1:0]  probe_off,
    output logic [WORDS-1:0]  arrived,
    output probe_res_t        probe_res,
    output logic [WORD_W-1:0] probe_data
);
    logic [WORD_W-1:0] words_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                arrived[i] <= 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(i))) begin
                arrived[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[i] <= '0;
            end else if (wr_en && (wr_off == OFF_W'(i))) begin
                words_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        probe_res.hit   = probe_en &&  arrived[probe_off];
        probe_res.stall = probe_en && !arrived[probe_off];
        probe_data      = words_q[probe_off];
    end

    // R8
    arrived_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(clear) |-> ((arrived & $past(arrived)) == $past(arrived)));

endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
    import cwf_pkg::*;
#(
    parameter  int WORDS  = 4,
    parameter  int WORD_W = 32,
    parameter  int LINE_W = 26,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_off,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [OFF_W-1:0]  mem_req_off,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              cpu_early_valid,
    output logic [OFF_W-1:0]  cpu_early_off,
    output logic [WORD_W-1:0] cpu_early_data,
    output logic              array_we,
    output logic [LINE_W-1:0] array_line,
    output logic [OFF_W-1:0]  array_off,
    output logic [WORD_W-1:0] array_data,
    output logic              fill_done,
    input  logic              probe_valid,
    input  logic [LINE_W-1:0] probe_line,
    input  logic [OFF_W-1:0]  probe_off,
    output logic              probe_hit,
    output logic              probe_stall,
    output logic [WORD_W-1:0] probe_data
);
    logic              start;
    logic              busy;
    logic              word_take;
    logic              first_word;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  cur_off;
    logic [WORDS-1:0]  arrived;
    probe_res_t        probe_res;
    logic              probe_en;

    cwf_ctrl #(
        .WORDS  (WORDS),
        .LINE_W (LINE_W)
    ) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .miss_line     (miss_line),
        .miss_off      (miss_off),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .miss_ready    (miss_ready),
        .start         (start),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .word_take     (word_take),
        .first_word    (first_word),
        .fill_done     (fill_done),
        .line_q        (line_q),
        .cur_off       (cur_off)
    );

    assign probe_en = busy && probe_valid && (probe_line == line_q);

    cwf_linebuf #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W)
    ) lbuf_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .wr_en      (word_take),
        .wr_off     (cur_off),
        .wr_data    (mem_rsp_data),
        .probe_en   (probe_en),
        .probe_off  (probe_off),
        .arrived    (arrived),
        .probe_res  (probe_res),
        .probe_data (probe_data)
    );

    assign mem_req_line    = line_q;
    assign mem_req_off     = cur_off;
    assign cpu_early_valid = word_take && first_word;
    assign cpu_early_off   = cur_off;
    assign cpu_early_data  = mem_rsp_data;
    assign array_we        = word_take;
    assign array_line      = line_q;
    assign array_off       = cur_off;
    assign array_data      = mem_rsp_data;
    assign probe_hit       = probe_res.hit;
    assign probe_stall     = probe_res.stall;

    // Offset of the previous array write, kept for the wrap-order check.
    logic [OFF_W-1:0] last_wr_q;
    always_ff @(posedge clk) begin
        if (rst)           last_wr_q <= '0;
        else if (array_we) last_wr_q <= array_off;
    end

    // R3
    wrap_order_chk: assert property (@(posedge clk) disable iff (rst)
        (array_we && !cpu_early_valid) |->
            (array_off == OFF_W'(wrap_next(32'(last_wr_q), WORDS))));

    // R7
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (&arrived));

    // R5
    early_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_early_valid |-> array_we);

    // R8
    probe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(probe_hit && probe_stall));

endmodule

// File: tb/cwf_refill_tb.sv
`timescale 1ns/1ps
module cwf_refill_tb_top;
    localparam int WORDS  = 4;
    localparam int WORD_W = 32;
    localparam int LINE_W = 26;
    localparam int OFF_W  = $clog2(WORDS);
    localparam int NFILL  = 48;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              miss_valid = 1'b0;
    logic              miss_ready;
    logic [LINE_W-1:0] miss_line = '0;
    logic [OFF_W-1:0]  miss_off = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [LINE_W-1:0] mem_req_line;
    logic [OFF_W-1:0]  mem_req_off;
    logic              mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic              cpu_early_valid;
    logic [OFF_W-1:0]  cpu_early_off;
    logic [WORD_W-1:0] cpu_early_data;
    logic              array_we;
    logic [LINE_W-1:0] array_line;
    logic [OFF_W-1:0]  array_off;
    logic [WORD_W-1:0] array_data;
    logic              fill_done;
    logic              probe_valid = 1'b0;
    logic [LINE_W-1:0] probe_line = '0;
    logic [OFF_W-1:0]  probe_off = '0;
    logic              probe_hit;
    logic              probe_stall;
    logic [WORD_W-1:0] probe_data;

    always #2 clk = ~clk;

    cwf_refill #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_W(LINE_W)) dut_i (.*);

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mem_word(input int line, input int off);
        return WORD_W'(line * 16 + off) ^ 32'hC0DE_0000;
    endfunction

    // Behavioural reference state
    int  m_phase;   // 0 idle, 1 requesting, 2 awaiting data, 3 done
    int  m_line, m_cur, m_cnt;
    bit  m_arr [WORDS];
    logic [WORD_W-1:0] m_dat [WORDS];
    bit  m_bogus;
    // Memory responder
    bit  r_pend;
    int  r_gap, r_line, r_off;
    int  seed = 7;
    int  fill_idx = 0;

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32'h7fff;
    endfunction

    initial begin
        m_phase = 0; m_line = 0; m_cur = 0; m_cnt = 0; m_bogus = 0;
        r_pend = 0; r_gap = 0; r_line = 0; r_off = 0;
        for (int i = 0; i < WORDS; i++) begin m_arr[i] = 0; m_dat[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: idle outputs while reset is held
        chk("R1 miss_ready", miss_ready, 1);
        chk("R1 mem_req_valid", mem_req_valid, 0);
        chk("R1 array_we", array_we, 0);
        chk("R1 fill_done", fill_done, 0);
        chk("R1 cpu_early_valid", cpu_early_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 miss_ready after release", miss_ready, 1);
        chk("R1 probe_stall after release", probe_stall, 0);
        while (fill_idx < NFILL || m_phase != 0) begin
            int r;
            bit match;
            bit take;
            @(negedge clk);
            r = rnd();
            mem_req_ready = (r % 4) != 0;
            if (r_pend && r_gap == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(r_line, r_off);
                r_pend = 0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = WORD_W'(rnd());
                if (r_pend) r_gap--;
            end
            r = rnd();
            if (m_phase == 0 && fill_idx < NFILL && (r % 3) != 0) begin
                miss_valid = 1'b1;
                miss_line  = LINE_W'(fill_idx * 37 + 5);
                miss_off   = OFF_W'(fill_idx % WORDS);
            end else if (m_phase != 0 && (r % 6) == 0) begin
                miss_valid = 1'b1;
                miss_line  = LINE_W'(999);
                miss_off   = OFF_W'(r >> 4);
            end else begin
                miss_valid = 1'b0;
            end
            r = rnd();
            probe_valid = r[0];
            probe_line  = r[1] ? LINE_W'(m_line) : LINE_W'(m_line + 1);
            probe_off   = OFF_W'(r >> 2);
            #1;
            // Compare against the reference
            chk("R4 mem_req_valid", mem_req_valid, m_phase == 1);
            if (m_phase == 1) begin
                chk(m_cnt == 0 ? "R2 first offset" : "R3 wrapped offset", mem_req_off, m_cur);
                chk(m_bogus ? "R9 line kept" : "R2 request line", mem_req_line, m_line);
            end
            take = (m_phase == 2) && mem_rsp_valid;
            chk("R6 array_we", array_we, take);
            if (take) begin
                chk("R6 array_off", array_off, m_cur);
                chk("R6 array_data", array_data, mem_rsp_data);
                chk("R6 array_line", array_line, m_line);
            end
            chk("R5 cpu_early_valid", cpu_early_valid, take && m_cnt == 0);
            if (take && m_cnt == 0) begin
                chk("R5 cpu_early_data", cpu_early_data, mem_rsp_data);
                chk("R5 cpu_early_off", cpu_early_off, m_cur);
            end
            chk("R7 fill_done", fill_done, m_phase == 3);
            if (m_phase == 3) chk("R7 done line", array_line, m_line);
            chk("R7 miss_ready", miss_ready, m_phase == 0);
            match = (m_phase != 0) && probe_valid && (int'(probe_line) == m_line);
            chk("R8 probe_hit", probe_hit, match && m_arr[probe_off]);
            chk("R8 probe_stall", probe_stall, match && !m_arr[probe_off]);
            if (match && m_arr[probe_off]) chk("R8 probe_data", probe_data, m_dat[probe_off]);
            // Advance the reference across the coming edge
            if (m_phase != 0 && miss_valid) m_bogus = 1;
            case (m_phase)
                0: if (miss_valid) begin
                    m_phase = 1; m_line = int'(miss_line); m_cur = int'(miss_off);
                    m_cnt = 0; m_bogus = 0; fill_idx++;
                    for (int i = 0; i < WORDS; i++) m_arr[i] = 0;
                end
                1: if (mem_req_ready) begin
                    m_phase = 2; r_pend = 1; r_gap = rnd() % 4;
                    r_line = m_line; r_off = m_cur;
                end
                2: if (mem_rsp_valid) begin
                    m_arr[m_cur] = 1; m_dat[m_cur] = mem_rsp_data;
                    m_cur = (m_cur + 1) % WORDS; m_cnt++;
                    m_phase = (m_cnt == WORDS) ? 3 : 1;
                end
                default: m_phase = 0;
            endcase
        end
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired, run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule